// File: doc/BRIEF.md
# Bus Mastership Handover Controller

This block sits beside a local bus master and hands the shared bus to a single external master, such as a DMA engine, through a three-wire handshake. The external side pulls an active-low request line. The block holds the local master off, waits for its bus cycle in flight to end, and then drives an active-low grant. The external master answers with an active-low acknowledge. From that point it owns the bus, and the block keeps the local bus drivers switched off.

Both external lines are asynchronous to the block clock. Each passes through a synchronizer whose depth is a parameter (two flops by default) before the control logic sees it. The local master reports, in its own clock domain, whether a cycle is in progress. When its cycle has ended and the grant goes out, it receives a one-cycle release pulse. If the external side withdraws its request before acknowledging, the grant is negated and the local master gets the bus back.

Top module: `arb_handshake`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bus_grant_n` is 1 and `loc_hold`, `loc_drv_off` and `loc_released` are 0.
- R2: `bus_req_n` and `grant_ack_n` are active low (0 = asserted) and each passes through two synchronizing flops. A request driven before clock edge E0 raises `loc_hold` after edge E2 and not earlier.
- R3: Once a request is seen, `loc_hold` goes to 1 at once. `bus_grant_n` stays 1 for as long as `loc_busy` is 1.
- R4: When `loc_hold` is 1, the request is still present and `loc_busy` is sampled 0, `bus_grant_n` goes to 0 on the next edge. On that same edge `loc_released` is 1 for exactly one cycle.
- R5: An acknowledge seen while granted drives `bus_grant_n` back to 1 and sets `loc_drv_off` to 1, with `loc_hold` remaining 1.
- R6: While the external master owns the bus, changes on `bus_req_n` have no effect. Releasing the acknowledge clears `loc_hold` and `loc_drv_off`.
- R7: If the request is withdrawn while the block is waiting for the local cycle to end or while it is granting, `bus_grant_n` returns to 1 and `loc_hold` to 0.
- R8: An acknowledge that arrives when no grant is pending is ignored: all outputs keep their idle values.
- R9: `bus_grant_n` = 0 and `loc_drv_off` = 1 never occur together, and `loc_drv_off` = 1 implies `loc_hold` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req_n | input | 1 | External request for the bus, active low, asynchronous |
| grant_ack_n | input | 1 | External confirmation of ownership, active low, asynchronous |
| loc_busy | input | 1 | Local master has a bus cycle in progress |
| bus_grant_n | output | 1 | Grant to the external master, active low |
| loc_hold | output | 1 | Local master must start no new cycle |
| loc_drv_off | output | 1 | Tri-state enable for the local bus drivers |
| loc_released | output | 1 | One-cycle pulse: local cycle finished, bus handed over |

## Verification
The assertions assume that `loc_busy` is synchronous to `clk` and that the local master starts no cycle while `loc_hold` is 1. They also assume that the external side follows request, then grant, then acknowledge, and keeps the acknowledge asserted until it is done with the bus. The stimulus changes `loc_busy` only on falling clock edges. It withdraws the request only after the acknowledge has been taken, or as a deliberate early abort before any acknowledge. It raises a stray acknowledge only when no request is pending.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

    typedef enum logic [1:0] {
        ST_LOCAL  = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_GRANT  = 2'd2,
        ST_REMOTE = 2'd3
    } arb_state_e;

    typedef struct packed {
        logic req;
        logic ack;
    } arb_in_t;

    typedef struct packed {
        logic grant;
        logic hold;
        logic drv_off;
        logic released;
    } arb_out_t;

    localparam int unsigned ARB_IN_W = $bits(arb_in_t);

    function automatic arb_in_t pins_to_active(input logic req_n, input logic ack_n);
        arb_in_t r;
        r.req = ~req_n;
        r.ack = ~ack_n;
        return r;
    endfunction

    function automatic arb_out_t decode_state(input arb_state_e st, input logic rel);
        arb_out_t o;
        o.grant    = (st == ST_GRANT);
        o.hold     = (st != ST_LOCAL);
        o.drv_off  = (st == ST_REMOTE);
        o.released = rel;
        return o;
    endfunction

endpackage

// File: rtl/arb_sync.sv
`timescale 1ns/1ps
module arb_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[LAST];
endmodule

// File: rtl/arb_fsm.sv
`timescale 1ns/1ps
module arb_fsm
    import arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arb_in_t  seen,
    input  logic     loc_busy,
    output arb_out_t outs
);
    arb_state_e state_q, state_d;
    logic       rel_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_LOCAL:  if (seen.req) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (!seen.req)     state_d = ST_LOCAL;
                else if (!loc_busy) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                if (seen.ack)      state_d = ST_REMOTE;
                else if (!seen.req) state_d = ST_LOCAL;
            end
            ST_REMOTE: if (!seen.ack) state_d = ST_LOCAL;
            default:   state_d = ST_LOCAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOCAL;
            rel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rel_q   <= (state_q == ST_DRAIN) && (state_d == ST_GRANT);
        end
    end

    assign outs = decode_state(state_q, rel_q);

    // R9
    grant_vs_off_chk: assert property (@(posedge clk) disable iff (rst)
        !(outs.grant && outs.drv_off));
    // R9
    off_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        outs.drv_off |-> outs.hold);
    // R3
    grant_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.grant) |-> $past(!loc_busy));
    // R2
    hold_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.hold) |-> $past(seen.req));
    // R4
    release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        outs.released |=> !outs.released);
    // R5
    off_from_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.drv_off) |-> $past(outs.grant));
    // R6
    remote_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (outs.drv_off && seen.ack) |=> outs.drv_off);
    // R7
    withdraw_chk: assert property (@(posedge clk) disable iff (rst)
        (outs.grant && !seen.req) |=> !outs.grant);
endmodule

// File: rtl/arb_handshake.sv
`timescale 1ns/1ps
module arb_handshake
    import arb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_req_n,
    input  logic grant_ack_n,
    input  logic loc_busy,
    output logic bus_grant_n,
    output logic loc_hold,
    output logic loc_drv_off,
    output logic loc_released
);
    arb_in_t  raw_act;
    arb_in_t  seen;
    arb_out_t outs;

    assign raw_act = pins_to_active(bus_req_n, grant_ack_n);

    arb_sync #(
        .WIDTH (ARB_IN_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(raw_act),
        .q_sync (seen)
    );

    arb_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .seen    (seen),
        .loc_busy(loc_busy),
        .outs    (outs)
    );

    assign bus_grant_n  = ~outs.grant;
    assign loc_hold     = outs.hold;
    assign loc_drv_off  = outs.drv_off;
    assign loc_released = outs.released;
endmodule

// File: tb/sim_arb_handshake.sv
`timescale 1ns/1ps
module sim_arb_handshake;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req_n = 1'b1;
    logic grant_ack_n = 1'b1;
    logic loc_busy = 1'b0;
    logic bus_grant_n, loc_hold, loc_drv_off, loc_released;

    always #2.5 clk = ~clk;

    arb_handshake u0 (
        .clk(clk), .rst(rst), .bus_req_n(bus_req_n), .grant_ack_n(grant_ack_n),
        .loc_busy(loc_busy), .bus_grant_n(bus_grant_n), .loc_hold(loc_hold),
        .loc_drv_off(loc_drv_off), .loc_released(loc_released)
    );

    typedef struct {
        logic  g_n;
        logic  hold;
        logic  off;
        logic  rel;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_out(input logic g_n, input logic hold, input logic off,
                              input logic rel, input string tag);
        exp_t e;
        e.g_n = g_n; e.hold = hold; e.off = off; e.rel = rel; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (bus_grant_n !== e.g_n || loc_hold !== e.hold ||
                    loc_drv_off !== e.off || loc_released !== e.rel) begin
                    n_bad++;
                    $display("FAIL %s: got g_n=%b hold=%b off=%b rel=%b exp g_n=%b hold=%b off=%b rel=%b",
                             e.tag, bus_grant_n, loc_hold, loc_drv_off, loc_released,
                             e.g_n, e.hold, e.off, e.rel);
                end
            end
        end
    end

    initial begin
        tick(3);
        expect_out(1, 0, 0, 0, "R1 in reset");
        rst = 1'b0;
        tick(1);
        expect_out(1, 0, 0, 0, "R1 after reset");

        // full handover, local idle
        bus_req_n = 1'b0;
        tick(2);
        expect_out(1, 0, 0, 0, "R2 not before third edge");
        tick(1);
        expect_out(1, 1, 0, 0, "R2 R3 hold raised");
        tick(1);
        expect_out(0, 1, 0, 1, "R4 grant with release pulse");
        tick(1);
        expect_out(0, 1, 0, 0, "R4 pulse one cycle");
        grant_ack_n = 1'b0;
        tick(2);
        expect_out(0, 1, 0, 0, "R2 ack still in sync");
        tick(1);
        expect_out(1, 1, 1, 0, "R5 R9 ack taken");
        bus_req_n = 1'b1;
        tick(4);
        expect_out(1, 1, 1, 0, "R6 request change ignored");
        grant_ack_n = 1'b0;
        tick(1);
        grant_ack_n = 1'b1;
        tick(3);
        expect_out(1, 0, 0, 0, "R6 bus returned");

        // local busy delays grant
        tick(2);
        loc_busy  = 1'b1;
        bus_req_n = 1'b0;
        tick(3);
        expect_out(1, 1, 0, 0, "R3 hold while busy");
        tick(5);
        expect_out(1, 1, 0, 0, "R3 no grant mid cycle");
        loc_busy = 1'b0;
        tick(1);
        expect_out(0, 1, 0, 1, "R4 grant after cycle end");
        bus_req_n = 1'b1;
        tick(2);
        expect_out(0, 1, 0, 0, "R7 grant until withdraw seen");
        tick(1);
        expect_out(1, 0, 0, 0, "R7 withdrawn while granted");

        // withdraw while draining
        tick(2);
        loc_busy  = 1'b1;
        bus_req_n = 1'b0;
        tick(3);
        expect_out(1, 1, 0, 0, "R3 draining");
        bus_req_n = 1'b1;
        tick(3);
        expect_out(1, 0, 0, 0, "R7 withdrawn while draining");
        loc_busy = 1'b0;

        // stray acknowledge
        tick(2);
        grant_ack_n = 1'b0;
        tick(3);
        expect_out(1, 0, 0, 0, "R8 stray ack ignored");
        tick(3);
        expect_out(1, 0, 0, 0, "R8 stray ack held");
        grant_ack_n = 1'b1;
        tick(4);
        expect_out(1, 0, 0, 0, "R8 idle after stray ack");

        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule